// File: doc/BRIEF.md
# I2C Single-Byte Master Engine

This block is a bus master for a two-wire serial bus that moves one byte per command. Software programs a target register (7-bit device address plus a direction bit), a data register and a clock divider, then writes a command word. The command picks whether a START (or repeated START) and address phase come first, and whether a STOP follows. A receive command also picks whether the byte is acknowledged. Each command moves exactly one byte. Longer transfers, and mixed write-then-read transfers, are built by issuing further commands while the engine keeps the bus.

Both bus lines are open-drain. Each line has an output enable, where 1 pulls the line low, and an input that returns the line level. A status byte reports busy, error, address and data not-acknowledge, lost arbitration, idle and bus-busy. A raw interrupt bit is set when a command ends, is gated by an enable bit, and is cleared by writing one to a clear register. A loopback mode feeds the engine's own line drive back to its inputs and releases the external pins.

Register offsets on `wr_addr`/`rd_addr`:

| Offset | Write | Read |
|--------|-------|------|
| 0 | target: bits 7:1 address, bit 0 direction (1 read, 0 write) | same |
| 1 | command | status |
| 2 | data | data |
| 3 | clock divider (7 bits) | same |
| 4 | interrupt enable (bit 0) | same |
| 5 | (none) | raw interrupt (bit 0) |
| 6 | (none) | gated interrupt (bit 0) |
| 7 | interrupt clear (bit 0) | 0 |
| 8 | configuration: bit 0 loopback, bit 1 master enable | same |

Top module: `i2c_byte_master`

## Requirements
- R1: A command with bit 0 = go, bit 1 = start and bit 2 = stop (value 0x7), issued with direction 0, emits START, the address byte, the data byte and STOP. Both lines are released afterwards and the addressed device receives the data byte.
- R2: With direction 1, the received byte is stored in the data register before the acknowledge bit is driven. Command bit 3 (ack) = 1 drives an acknowledge after the byte; ack = 0 leaves SDA released (not-acknowledge).
- R3: A command with stop = 0 keeps the bus when it ends: SCL stays pulled low and status bit 5 (idle) reads 0. A later command with start = 0 moves only one data byte on the held bus. A later command with start = 1 produces a repeated START.
- R4: If the address is not acknowledged, status bits 2 and 1 are set and no data byte is transferred. A STOP is still generated when stop = 1.
- R5: If a transmitted data byte is not acknowledged, status bits 3 and 1 are set.
- R6: If SDA reads low at the SCL-high sample point while the engine is sending a 1, arbitration is lost. The engine releases both lines at once, generates no STOP, sets status bits 4 and 1, and ends the command.
- R7: Status bit 6 (bus busy) goes to 1 when a START is seen on the lines and back to 0 when a STOP is seen.
- R8: Status bit 0 (busy) is 1 while a command runs, and bit 5 is then 0. Every accepted command clears status bits 1 to 4 from the previous command.
- R9: The end of every accepted command sets the raw interrupt. The `irq` output is raw AND enable. Writing 1 to the clear register clears raw and `irq`.
- R10: In loopback (configuration bit 0 = 1) both pin enables stay 0 and the engine sees its own drive. An address phase therefore ends in not-acknowledge.
- R11: A command word is ignored when its go bit is 0 or when master enable (configuration bit 1) is 0. No bus activity, status change or interrupt follows.
- R12: One bit time is four quarters of (divider + 1) clocks each, and SCL is released for two quarters per bit.
- R13: A go command with start = 0 while the bus is not held ends at once with status bit 1 set, and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Gated completion interrupt |

## Verification
Lost arbitration is the hardest case to produce from the ports. It needs another master to pull SDA low during an SCL-low phase that precedes a bit the engine sends as 1, and to keep it low across the following SCL-high sample point. The bench wires both lines as wired-AND of the engine, a behavioural target device and a rival pull-down. It waits for the engine's first SCL pull after START, then asserts the rival on an address whose first bit is 1. It then checks the released lines and the status, and after releasing the rival it checks that the bus-busy flag falls when the line-level STOP is seen.

// File: rtl/i2c_pkg.sv
package i2c_pkg;

  localparam int unsigned REG_AW = 4;
  localparam int unsigned BYTE_W = 8;

  localparam logic [REG_AW-1:0] OFF_TGT  = 4'd0;
  localparam logic [REG_AW-1:0] OFF_CMD  = 4'd1;
  localparam logic [REG_AW-1:0] OFF_DAT  = 4'd2;
  localparam logic [REG_AW-1:0] OFF_DIV  = 4'd3;
  localparam logic [REG_AW-1:0] OFF_IEN  = 4'd4;
  localparam logic [REG_AW-1:0] OFF_IRAW = 4'd5;
  localparam logic [REG_AW-1:0] OFF_IGAT = 4'd6;
  localparam logic [REG_AW-1:0] OFF_ICLR = 4'd7;
  localparam logic [REG_AW-1:0] OFF_CFG  = 4'd8;

  localparam int unsigned CMD_GO    = 0;
  localparam int unsigned CMD_START = 1;
  localparam int unsigned CMD_STOP  = 2;
  localparam int unsigned CMD_ACK   = 3;

  localparam int unsigned CFG_LOOP = 0;
  localparam int unsigned CFG_MEN  = 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_ADDR,
    PH_AACK,
    PH_DATA,
    PH_DACK,
    PH_STOP
  } phase_e;

  // a quarter ends once the counter has reached the divider value
  function automatic logic quarter_done(int unsigned cnt, int unsigned div);
    return cnt >= div;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(
      logic busy, logic err, logic adr_nack, logic dat_nack,
      logic arb, logic idle, logic bus_busy);
    return {1'b0, bus_busy, idle, arb, dat_nack, adr_nack, err, busy};
  endfunction

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  import i2c_pkg::*;

  logic [DIV_W-1:0] cnt;

  assign tick = run && quarter_done(32'(cnt), 32'(div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_line_watch.sv
module i2c_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_det,
  output logic stop_det,
  output logic bus_busy
);
  logic scl_q, sda_q;

  assign start_det = scl && scl_q && sda_q && !sda;
  assign stop_det  = scl && scl_q && !sda_q && sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_det)     bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_ack,
  input  logic [7:0] tgt_byte,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       scl_drv,
  output logic       sda_drv,
  output logic       busy,
  output logic       hold,
  output logic       in_data,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       done_p,
  output logic       arb_p,
  output logic       adr_nack_p,
  output logic       f_err,
  output logic       f_adr,
  output logic       f_dat,
  output logic       f_arb
);
  import i2c_pkg::*;

  phase_e     st;
  logic [1:0] q;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       rd, stop_req, ack_req, nack_s;
  logic       rx_mode;

  assign busy    = (st != PH_IDLE);
  assign in_data = (st == PH_DATA);
  assign rx_mode = (st == PH_DATA) && rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PH_IDLE; q <= '0; bitn <= '0; sh <= '0;
      rd <= 1'b0; stop_req <= 1'b0; ack_req <= 1'b0; nack_s <= 1'b0;
      scl_drv <= 1'b0; sda_drv <= 1'b0; hold <= 1'b0;
      rx_byte <= '0; rx_valid <= 1'b0;
      done_p <= 1'b0; arb_p <= 1'b0; adr_nack_p <= 1'b0;
      f_err <= 1'b0; f_adr <= 1'b0; f_dat <= 1'b0; f_arb <= 1'b0;
    end else begin
      done_p     <= 1'b0;
      arb_p      <= 1'b0;
      adr_nack_p <= 1'b0;
      rx_valid   <= 1'b0;
      if (st == PH_IDLE) begin
        if (go) begin
          f_err <= 1'b0; f_adr <= 1'b0; f_dat <= 1'b0; f_arb <= 1'b0;
          stop_req <= cmd_stop;
          ack_req  <= cmd_ack;
          rd       <= tgt_byte[0];
          q        <= '0;
          if (cmd_start) begin
            st <= PH_START;
            sh <= tgt_byte;
          end else if (hold) begin
            st   <= PH_DATA;
            bitn <= 3'd7;
            sh   <= tx_byte;
          end else begin
            f_err  <= 1'b1;
            done_p <= 1'b1;
          end
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (st)
          PH_START: begin
            case (q)
              2'd0: sda_drv <= 1'b0;
              2'd1: scl_drv <= 1'b0;
              2'd2: sda_drv <= 1'b1;
              default: begin
                scl_drv <= 1'b1;
                hold    <= 1'b1;
                bitn    <= 3'd7;
                st      <= PH_ADDR;
              end
            endcase
          end
          PH_ADDR, PH_DATA: begin
            case (q)
              2'd0: sda_drv <= rx_mode ? 1'b0 : !sh[7];
              2'd1: scl_drv <= 1'b0;
              2'd2: begin
                if (rx_mode) begin
                  sh <= {sh[6:0], sda_in};
                end else if (sh[7] && !sda_in) begin
                  scl_drv <= 1'b0;
                  sda_drv <= 1'b0;
                  hold    <= 1'b0;
                  f_arb   <= 1'b1;
                  f_err   <= 1'b1;
                  arb_p   <= 1'b1;
                  done_p  <= 1'b1;
                  q       <= '0;
                  st      <= PH_IDLE;
                end
              end
              default: begin
                scl_drv <= 1'b1;
                if (!rx_mode) sh <= {sh[6:0], 1'b0};
                if (bitn == 3'd0) begin
                  if (rx_mode) begin
                    rx_byte  <= sh;
                    rx_valid <= 1'b1;
                  end
                  st <= (st == PH_ADDR) ? PH_AACK : PH_DACK;
                end else begin
                  bitn <= bitn - 3'd1;
                end
              end
            endcase
          end
          PH_AACK: begin
            case (q)
              2'd0: sda_drv <= 1'b0;
              2'd1: scl_drv <= 1'b0;
              2'd2: nack_s  <= sda_in;
              default: begin
                scl_drv <= 1'b1;
                if (nack_s) begin
                  f_adr      <= 1'b1;
                  f_err      <= 1'b1;
                  adr_nack_p <= 1'b1;
                  st         <= stop_req ? PH_STOP : PH_IDLE;
                  done_p     <= !stop_req;
                end else begin
                  st   <= PH_DATA;
                  bitn <= 3'd7;
                  sh   <= tx_byte;
                end
              end
            endcase
          end
          PH_DACK: begin
            case (q)
              2'd0: sda_drv <= rd ? ack_req : 1'b0;
              2'd1: scl_drv <= 1'b0;
              2'd2: if (!rd) nack_s <= sda_in;
              default: begin
                scl_drv <= 1'b1;
                if (!rd && nack_s) begin
                  f_dat <= 1'b1;
                  f_err <= 1'b1;
                end
                st     <= stop_req ? PH_STOP : PH_IDLE;
                done_p <= !stop_req;
              end
            endcase
          end
          PH_STOP: begin
            case (q)
              2'd0: sda_drv <= 1'b1;
              2'd1: scl_drv <= 1'b0;
              2'd2: sda_drv <= 1'b0;
              default: begin
                hold   <= 1'b0;
                done_p <= 1'b1;
                st     <= PH_IDLE;
              end
            endcase
          end
          default: st <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned DIV_RST = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  import i2c_pkg::*;

  localparam int unsigned PAD_W = BYTE_W - DIV_W;

  logic [7:0]       tgt_q, dat_q;
  logic [DIV_W-1:0] div_q;
  logic             ien_q, raw_q, loop_q, men_q;

  // named internal events, also used by the bound checker
  logic       tick, go, clr_wr, busy, hold, in_data;
  logic       done_p, arb_p, adr_nack_p, rx_valid;
  logic       start_det, stop_det, busbsy;
  logic       scl_drv, sda_drv, scl_eff, sda_eff;
  logic       f_err, f_adr, f_dat, f_arb;
  logic [7:0] rx_byte, sts;

  assign go     = wr_en && (wr_addr == OFF_CMD) && wr_data[CMD_GO] && men_q && !busy;
  assign clr_wr = wr_en && (wr_addr == OFF_ICLR) && wr_data[0];

  assign scl_eff = loop_q ? !scl_drv : scl_i;
  assign sda_eff = loop_q ? !sda_drv : sda_i;
  assign scl_oe  = scl_drv && !loop_q;
  assign sda_oe  = sda_drv && !loop_q;
  assign irq     = raw_q && ien_q;

  assign sts = pack_status(busy, f_err, f_adr, f_dat, f_arb, !busy && !hold, busbsy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      dat_q  <= '0;
      div_q  <= DIV_W'(DIV_RST);
      ien_q  <= 1'b0;
      raw_q  <= 1'b0;
      loop_q <= 1'b0;
      men_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == OFF_TGT) tgt_q <= wr_data;
      if (rx_valid)                        dat_q <= rx_byte;
      else if (wr_en && wr_addr == OFF_DAT) dat_q <= wr_data;
      if (wr_en && wr_addr == OFF_DIV) div_q <= wr_data[DIV_W-1:0];
      if (wr_en && wr_addr == OFF_IEN) ien_q <= wr_data[0];
      if (wr_en && wr_addr == OFF_CFG) begin
        loop_q <= wr_data[CFG_LOOP];
        men_q  <= wr_data[CFG_MEN];
      end
      if (done_p)      raw_q <= 1'b1;
      else if (clr_wr) raw_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      OFF_TGT:  rd_data = tgt_q;
      OFF_CMD:  rd_data = sts;
      OFF_DAT:  rd_data = dat_q;
      OFF_DIV:  rd_data = {{PAD_W{1'b0}}, div_q};
      OFF_IEN:  rd_data = {7'd0, ien_q};
      OFF_IRAW: rd_data = {7'd0, raw_q};
      OFF_IGAT: rd_data = {7'd0, irq};
      OFF_CFG:  rd_data = {6'd0, men_q, loop_q};
      default:  rd_data = '0;
    endcase
  end

  i2c_quarter_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  i2c_line_watch u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_eff),
    .sda      (sda_eff),
    .start_det(start_det),
    .stop_det (stop_det),
    .bus_busy (busbsy)
  );

  i2c_byte_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .go        (go),
    .cmd_start (wr_data[CMD_START]),
    .cmd_stop  (wr_data[CMD_STOP]),
    .cmd_ack   (wr_data[CMD_ACK]),
    .tgt_byte  (tgt_q),
    .tx_byte   (dat_q),
    .sda_in    (sda_eff),
    .scl_drv   (scl_drv),
    .sda_drv   (sda_drv),
    .busy      (busy),
    .hold      (hold),
    .in_data   (in_data),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .done_p    (done_p),
    .arb_p     (arb_p),
    .adr_nack_p(adr_nack_p),
    .f_err     (f_err),
    .f_adr     (f_adr),
    .f_dat     (f_dat),
    .f_arb     (f_arb)
  );
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       hold,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       done_p,
  input logic       arb_p,
  input logic       adr_nack_p,
  input logic       in_data,
  input logic       start_det,
  input logic       busbsy,
  input logic       raw_q,
  input logic       clr_wr,
  input logic [7:0] sts
);
  a_r3_free_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hold) |-> (!scl_oe && !sda_oe));

  a_r6_arb_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    arb_p |-> (!scl_oe && !sda_oe && !busy));

  a_r4_no_data_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    adr_nack_p |=> !in_data);

  a_r7_busbsy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busbsy);

  a_r9_raw_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> raw_q);

  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !done_p) |=> !raw_q);

  a_r8_busy_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sts[0] |-> !sts[5]);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .hold      (hold),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .done_p    (done_p),
  .arb_p     (arb_p),
  .adr_nack_p(adr_nack_p),
  .in_data   (in_data),
  .start_det (start_det),
  .busbsy    (busbsy),
  .raw_q     (raw_q),
  .clr_wr    (clr_wr),
  .sts       (sts)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       scl_oe, sda_oe, irq;
  logic       scl_line, sda_line;
  logic       rival = 1'b0;

  // behavioural target device
  localparam logic [6:0] DEV = 7'h2A;
  logic       m_pull, m_act, m_abyte, m_sel, m_rd, m_mack;
  logic       m_ps, m_pd, m_sack;
  logic [3:0] m_bn;
  logic [7:0] m_sh, m_rx, m_stx;
  int         m_starts;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || m_pull || rival);

  always #2 clk = !clk;

  i2c_byte_master i_i2c_byte_master (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .scl_i  (scl_line),
    .sda_i  (sda_line),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .irq    (irq)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pull <= 1'b0; m_act <= 1'b0; m_abyte <= 1'b0; m_sel <= 1'b0;
      m_rd <= 1'b0; m_bn <= '0; m_sh <= '0; m_ps <= 1'b1; m_pd <= 1'b1;
      m_starts <= 0;
    end else begin
      if (scl_line && m_ps && m_pd && !sda_line) begin
        m_act <= 1'b1; m_abyte <= 1'b1; m_bn <= '0; m_pull <= 1'b0;
        m_sel <= 1'b0; m_starts <= m_starts + 1;
      end else if (scl_line && m_ps && !m_pd && sda_line) begin
        m_act <= 1'b0; m_pull <= 1'b0;
      end else if (m_act && scl_line && !m_ps) begin
        if (m_bn < 4'd8) begin
          if (!(m_sel && m_rd && !m_abyte)) m_sh <= {m_sh[6:0], sda_line};
        end else if (m_sel && m_rd && !m_abyte) begin
          m_mack <= !sda_line;
        end
        m_bn <= m_bn + 4'd1;
      end else if (m_act && !scl_line && m_ps) begin
        if (m_bn == 4'd8) begin
          if (m_abyte) begin
            m_sel  <= (m_sh[7:1] == DEV);
            m_rd   <= m_sh[0];
            m_pull <= (m_sh[7:1] == DEV);
          end else if (m_sel && !m_rd) begin
            m_rx   <= m_sh;
            m_pull <= m_sack;
          end else begin
            m_pull <= 1'b0;
          end
        end else if (m_bn == 4'd9) begin
          m_bn <= '0; m_abyte <= 1'b0;
          m_pull <= m_sel && m_rd && (m_abyte || m_mack) && !m_stx[7];
        end else if (m_sel && m_rd && !m_abyte && m_bn >= 4'd1 && m_bn <= 4'd7) begin
          m_pull <= !m_stx[3'd7 - m_bn[2:0]];
        end
      end
      m_ps <= scl_line;
      m_pd <= sda_line;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    int n = 0;
    do begin
      rd(4'd1, s);
      n++;
    end while (s[0] && n < 20000);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] tgt;
    logic [7:0] dat;
    logic [3:0] cmd;
    logic       sack;
    logic [7:0] stx;
    logic [7:0] sts;
    logic [7:0] dreg;
    logic [7:0] srx;
    logic       mack;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h54, 8'hA5, 4'h7, 1'b1, 8'h00, 8'h20, 8'hA5, 8'hA5, 1'b0},
    '{8'h22, 8'h5A, 4'h7, 1'b1, 8'h00, 8'h26, 8'h5A, 8'h00, 1'b0},
    '{8'h54, 8'h0F, 4'h7, 1'b0, 8'h00, 8'h2A, 8'h0F, 8'h0F, 1'b0},
    '{8'h55, 8'h00, 4'h7, 1'b1, 8'h3C, 8'h20, 8'h3C, 8'h00, 1'b0},
    '{8'h55, 8'h00, 4'hF, 1'b1, 8'h96, 8'h20, 8'h96, 8'h00, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int st0, n;
    bit bad;
    m_sack = 1'b1; m_stx = '0; m_rx = '0; m_mack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state (R8, R9, R12)
    rd(4'd1, v); chk("R8 reset status", v, 8'h20);
    rd(4'd5, v); chk("R9 reset raw", v, 0);
    chk("R9 reset irq", irq, 0);
    chk("R3 reset pins", {scl_oe, sda_oe}, 0);
    rd(4'd3, v); chk("R12 reset divider", v, 1);

    // R11: master disabled ignores a full command
    wr(4'd0, 8'h54); wr(4'd2, 8'h11);
    wr(4'd1, 8'h07);
    bad = 1'b0;
    repeat (40) begin @(negedge clk); if (scl_oe || sda_oe) bad = 1'b1; end
    chk("R11 disabled no bus activity", bad, 0);
    rd(4'd1, v); chk("R11 disabled status", v, 8'h20);
    rd(4'd5, v); chk("R11 disabled raw", v, 0);

    wr(4'd8, 8'h02);
    // R11: go bit clear is ignored
    wr(4'd1, 8'h06);
    bad = 1'b0;
    repeat (40) begin @(negedge clk); if (scl_oe || sda_oe) bad = 1'b1; end
    chk("R11 go=0 no bus activity", bad, 0);
    rd(4'd5, v); chk("R11 go=0 raw", v, 0);

    // table walk: R1 R2 R4 R5 R8 R9
    for (int i = 0; i < 5; i++) begin
      m_sack = VEC[i].sack; m_stx = VEC[i].stx;
      m_rx = '0; m_mack = !VEC[i].mack;
      wr(4'd0, VEC[i].tgt);
      wr(4'd2, VEC[i].dat);
      wr(4'd1, {4'd0, VEC[i].cmd});
      wait_done();
      rd(4'd1, v); chk($sformatf("R1 R4 R5 R8 vec%0d status", i), v, VEC[i].sts);
      rd(4'd2, v); chk($sformatf("R2 vec%0d data reg", i), v, VEC[i].dreg);
      chk($sformatf("R1 R4 vec%0d device rx", i), m_rx, VEC[i].srx);
      if (VEC[i].tgt[0]) chk($sformatf("R2 vec%0d master ack", i), m_mack, VEC[i].mack);
      chk($sformatf("R1 vec%0d lines released", i), {scl_oe, sda_oe}, 0);
      rd(4'd5, v); chk($sformatf("R9 vec%0d raw set", i), v, 1);
      wr(4'd7, 8'h01);
      rd(4'd5, v); chk($sformatf("R9 vec%0d raw cleared", i), v, 0);
    end

    // R3 R7: hold the bus, then continue with start=0
    m_sack = 1'b1; m_rx = '0;
    wr(4'd0, 8'h54); wr(4'd2, 8'h11);
    wr(4'd1, 8'h03);
    wait_done();
    rd(4'd1, v); chk("R3 R7 held status", v, 8'h40);
    chk("R3 held scl pulled", scl_oe, 1);
    chk("R3 first byte", m_rx, 8'h11);
    st0 = m_starts;
    wr(4'd2, 8'h22);
    wr(4'd1, 8'h05);
    wait_done();
    rd(4'd1, v); chk("R3 R7 continue status", v, 8'h20);
    chk("R3 continued byte", m_rx, 8'h22);
    chk("R3 no new start on continue", m_starts, st0);

    // R3: repeated start turning write into read
    wr(4'd2, 8'h33);
    wr(4'd1, 8'h03);
    wait_done();
    st0 = m_starts;
    m_stx = 8'h77;
    wr(4'd0, 8'h55);
    wr(4'd1, 8'h07);
    wait_done();
    chk("R3 repeated start seen", m_starts, st0 + 1);
    rd(4'd2, v); chk("R2 R3 read after repeated start", v, 8'h77);
    rd(4'd1, v); chk("R3 status after repeated start", v, 8'h20);
    wr(4'd7, 8'h01);

    // R13: start=0 on a free bus
    st0 = m_starts;
    wr(4'd1, 8'h05);
    repeat (3) @(negedge clk);
    rd(4'd1, v); chk("R13 error status", v, 8'h22);
    chk("R13 no start", m_starts, st0);
    rd(4'd5, v); chk("R13 raw set", v, 1);

    // R9: enable gating
    chk("R9 irq masked", irq, 0);
    wr(4'd4, 8'h01);
    chk("R9 irq enabled", irq, 1);
    rd(4'd6, v); chk("R9 gated read", v, 1);
    wr(4'd7, 8'h01);
    chk("R9 irq after clear", irq, 0);
    rd(4'd5, v); chk("R9 raw after clear", v, 0);

    // R10: loopback
    st0 = m_starts;
    wr(4'd8, 8'h03);
    wr(4'd0, 8'h54);
    wr(4'd1, 8'h07);
    bad = 1'b0;
    repeat (200) begin @(negedge clk); if (scl_oe || sda_oe) bad = 1'b1; end
    wait_done();
    chk("R10 pins idle in loopback", bad, 0);
    rd(4'd1, v); chk("R10 loopback nack status", v, 8'h26);
    chk("R10 no external start", m_starts, st0);
    wr(4'd8, 8'h02);

    // R6 R7: lost arbitration
    wr(4'd0, 8'hB4);
    wr(4'd1, 8'h07);
    n = 0;
    while (!scl_oe && n < 1000) begin @(negedge clk); n++; end
    rival = 1'b1;
    wait_done();
    rd(4'd1, v); chk("R6 R7 arbitration status", v, 8'h72);
    chk("R6 lines released", {scl_oe, sda_oe}, 0);
    @(negedge clk); rival = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd1, v); chk("R7 bus free after stop", v, 8'h32);

    // R12: SCL high time with divider 3
    wr(4'd2, 8'h01);
    wr(4'd3, 8'h03);
    wr(4'd0, 8'h54);
    wr(4'd1, 8'h07);
    n = 0;
    while (!scl_oe && n < 1000) begin @(negedge clk); n++; end
    while (!scl_line && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    while (scl_line && n < 100) begin n++; @(negedge clk); end
    chk("R12 scl high clocks", n, 8);
    wait_done();
    rd(4'd1, v); chk("R12 R1 status at divider 3", v, 8'h20);
    wr(4'd3, 8'h01);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule